// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits beside an 8-bit processor core and takes over the core's state registers while an interrupt is entered or left. Four sources can raise a request: timer 0 (shared with the real-time tick), timer 1, the external pin and the software trap. Each request is caught in a pending latch. The block accepts a request only when three conditions hold: the core signals an instruction boundary, the mask bit of the status register is clear, and the source is enabled. When several requests are waiting, a fixed priority picks one.

On acceptance the block saves the core's state to a byte-wide stack memory, one byte per cycle. It then loads the fixed vector for the winning source, forces the page to 3 and sets the mask bit. A return command from the core reads the four bytes back in reverse order and restores the program counter, the page and the status. The restored status has the mask bit cleared, so any request that waited is served next.

While the core is halted in its stop state, a pending and enabled external request drives a wake signal.

Top module: `irq_entry_seq`

## Requirements
- R1: When more than one eligible request is pending, the source with the lowest code wins. The codes are 0 timer0/real-time, 1 timer1, 2 external, 3 software, and the winner's code appears on `ack_src_o` in the cycle that `ack_o` is high.
- R2: The program counter is loaded with 0x3FF0 for code 0, 0x3FE0 for code 1, 0x3FD0 for code 2 and 0x3FC0 for code 3.
- R3: Entry takes one accept cycle and then four write cycles, so `busy_o` stays high for four cycles after `ack_o`. The writes go to addresses SP, SP-1, SP-2 and SP-3 and store, in that order:
  - PC[7:0];
  - {2'b00, PC[13:8]};
  - {2'b00, page};
  - the status byte.
  
  SP is lowered by one after each write and ends 4 below its starting value.
- R4: When entry completes, the page is 3 and the status equals the saved status with bit 4 (the mask) set.
- R5: While status bit 4 is 1, no request is accepted. Requests that arrive during this time stay pending and are served once the bit is clear.
- R6: A return command (`ret_i` high in an idle cycle at a boundary) raises SP by one before each of four reads. The reads fetch status, page, PC high and PC low. The sequence lasts five busy cycles and restores PC, page, and status with bit 4 cleared, leaving SP 4 above its value before the return.
- R7: Enable bit 0 gates timer0, bit 1 gates timer1 and bit 2 gates external. Software requests need no enable. A disabled request stays pending and is served once its bit is set.
- R8: `wake_o` is high exactly when `stop_i` is high and an external request is pending with enable bit 2 set.
- R9: Acceptance clears only the winner's pending latch. The other pending requests stay pending, and nothing is accepted once all are served.
- R10: After reset no request is pending, `busy_o`, `ack_o`, `mem_we_o` and `wake_o` are low.
- R11: Nothing is accepted while `boundary_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Request pulses, bit = source code |
| irq_en_i | input | 3 | Enables for codes 0..2 |
| boundary_i | input | 1 | Core is at an instruction boundary |
| ret_i | input | 1 | Return-from-interrupt command |
| stop_i | input | 1 | Core is in the stop state |
| cur_pc_i | input | 14 | Core program counter |
| cur_page_i | input | 6 | Core fetch page |
| cur_ps_i | input | 8 | Core status register |
| cur_sp_i | input | 8 | Core stack pointer |
| mem_we_o | output | 1 | Stack write strobe |
| mem_addr_o | output | 8 | Stack address |
| mem_wdata_o | output | 8 | Stack write data |
| mem_rdata_i | input | 8 | Stack read data, one cycle after address |
| sp_ld_o | output | 1 | Load stack pointer |
| sp_nxt_o | output | 8 | New stack pointer |
| pc_ld_o | output | 1 | Load program counter |
| pc_nxt_o | output | 14 | New program counter |
| page_ld_o | output | 1 | Load fetch page and page register |
| page_nxt_o | output | 6 | New page |
| ps_ld_o | output | 1 | Load status register |
| ps_nxt_o | output | 8 | New status |
| ack_o | output | 1 | Request accepted this cycle |
| ack_src_o | output | 2 | Code of accepted source |
| busy_o | output | 1 | Entry or return sequence running |
| wake_o | output | 1 | Wake request from stop |

## Verification
The bench builds the block with its default parameters: a 14-bit counter, a 6-bit page, byte data and four sources. With only four sources, all fifteen non-empty sets of simultaneous requests can be swept. For each set, the bench serves the whole chain through repeated returns and checks the service order, the stack bytes and the restored state arithmetically. Directed passes cover the mask, the enables, the boundary and wake.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_d, pend_q;

    for (genvar i = 0; i < N; i++) begin : g_lat
        // a new request in the same cycle as its acceptance is kept
        assign pend_d[i] = set_i[i] | (pend_q[i] & ~clr_i[i]);

        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !pend_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  en_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    logic [N-1:0] elig;
    assign elig = pend_i & en_i;

    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                idx_o   = IW'(i);
                any_o   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int          PC_W     = 14,
    parameter int          PAGE_W   = 6,
    parameter int          DW       = 8,
    parameter int          SRC_N    = 4,
    parameter int          MASK_BIT = 4,
    parameter int          VEC_PAGE = 3,
    parameter int          VEC_TOP  = 'h3FF0,
    parameter int          VEC_STEP = 16,
    localparam int         IW       = $clog2(SRC_N),
    localparam int         EN_W     = SRC_N - 1,
    localparam int         PCH_W    = PC_W - DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  req_i,
    input  logic [EN_W-1:0]   irq_en_i,
    input  logic              boundary_i,
    input  logic              ret_i,
    input  logic              stop_i,
    input  logic [PC_W-1:0]   cur_pc_i,
    input  logic [PAGE_W-1:0] cur_page_i,
    input  logic [DW-1:0]     cur_ps_i,
    input  logic [DW-1:0]     cur_sp_i,
    output logic              mem_we_o,
    output logic [DW-1:0]     mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              sp_ld_o,
    output logic [DW-1:0]     sp_nxt_o,
    output logic              pc_ld_o,
    output logic [PC_W-1:0]   pc_nxt_o,
    output logic              page_ld_o,
    output logic [PAGE_W-1:0] page_nxt_o,
    output logic              ps_ld_o,
    output logic [DW-1:0]     ps_nxt_o,
    output logic              ack_o,
    output logic [IW-1:0]     ack_src_o,
    output logic              busy_o,
    output logic              wake_o
);
    localparam int EXT_IDX = 2;

    typedef struct packed {
        seq_state_e        st;
        logic [2:0]        step;
        logic [PC_W-1:0]   pc;
        logic [PAGE_W-1:0] page;
        logic [DW-1:0]     ps;
    } seq_s;

    seq_s s_d, s_q;

    logic [SRC_N-1:0] pend, grant, clr, en_full;
    logic [IW-1:0]    win;
    logic             any;

    assign en_full = {1'b1, irq_en_i};

    irq_pend #(.N(SRC_N)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(req_i), .clr_i(clr), .pend_o(pend)
    );

    irq_pick #(.N(SRC_N)) u_pick (
        .pend_i(pend), .en_i(en_full), .grant_o(grant), .idx_o(win), .any_o(any)
    );

    function automatic logic [PC_W-1:0] vec_of(input logic [IW-1:0] idx);
        return PC_W'(VEC_TOP - int'(idx) * VEC_STEP);
    endfunction

    always_comb begin
        s_d         = s_q;
        clr         = '0;
        mem_we_o    = 1'b0;
        mem_addr_o  = cur_sp_i;
        mem_wdata_o = '0;
        sp_ld_o     = 1'b0;
        sp_nxt_o    = cur_sp_i;
        pc_ld_o     = 1'b0;
        pc_nxt_o    = vec_of(win);
        page_ld_o   = 1'b0;
        page_nxt_o  = PAGE_W'(VEC_PAGE);
        ps_ld_o     = 1'b0;
        ps_nxt_o    = s_q.ps;
        ack_o       = 1'b0;
        ack_src_o   = win;
        case (s_q.st)
            ST_IDLE: begin
                if (boundary_i) begin
                    if (ret_i) begin
                        s_d.st   = ST_POP;
                        s_d.step = '0;
                    end else if (!cur_ps_i[MASK_BIT] && any) begin
                        ack_o    = 1'b1;
                        clr      = grant;
                        s_d.st   = ST_PUSH;
                        s_d.step = '0;
                        s_d.pc   = vec_of(win);
                        s_d.page = cur_page_i;
                        s_d.ps   = cur_ps_i;
                    end
                end
            end
            ST_PUSH: begin
                mem_we_o = 1'b1;
                sp_ld_o  = 1'b1;
                sp_nxt_o = cur_sp_i - 1'b1;
                case (s_q.step)
                    3'd0:    mem_wdata_o = cur_pc_i[DW-1:0];
                    3'd1:    mem_wdata_o = DW'(cur_pc_i[PC_W-1:DW]);
                    3'd2:    mem_wdata_o = DW'(s_q.page);
                    default: mem_wdata_o = s_q.ps;
                endcase
                s_d.step = s_q.step + 3'd1;
                if (s_q.step == 3'd3) begin
                    pc_ld_o   = 1'b1;
                    pc_nxt_o  = s_q.pc;
                    page_ld_o = 1'b1;
                    ps_ld_o   = 1'b1;
                    ps_nxt_o  = s_q.ps | DW'(1 << MASK_BIT);
                    s_d.st    = ST_IDLE;
                end
            end
            ST_POP: begin
                if (s_q.step != 3'd4) begin
                    mem_addr_o = cur_sp_i + 1'b1;
                    sp_ld_o    = 1'b1;
                    sp_nxt_o   = cur_sp_i + 1'b1;
                end
                case (s_q.step)
                    3'd1: s_d.ps = mem_rdata_i;
                    3'd2: s_d.page = mem_rdata_i[PAGE_W-1:0];
                    3'd3: s_d.pc[PC_W-1:DW] = mem_rdata_i[PCH_W-1:0];
                    default: ;
                endcase
                s_d.step = s_q.step + 3'd1;
                if (s_q.step == 3'd4) begin
                    pc_ld_o    = 1'b1;
                    pc_nxt_o   = {s_q.pc[PC_W-1:DW], mem_rdata_i};
                    page_ld_o  = 1'b1;
                    page_nxt_o = s_q.page;
                    ps_ld_o    = 1'b1;
                    ps_nxt_o   = s_q.ps & ~DW'(1 << MASK_BIT);
                    s_d.st     = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, step: '0, pc: '0, page: '0, ps: '0};
        else        s_q <= s_d;
    end

    assign busy_o = (s_q.st != ST_IDLE);
    assign wake_o = stop_i & pend[EXT_IDX] & irq_en_i[EXT_IDX];

    // R1: at most one source granted
    p_onehot_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R3: first save lands at the stack pointer seen at acceptance
    p_push_follows_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> (mem_we_o && mem_addr_o == $past(cur_sp_i)));
    // R6: return starts by raising the stack pointer
    p_pop_starts_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && boundary_i && ret_i) |=>
            (sp_ld_o && !mem_we_o && sp_nxt_o == DW'($past(cur_sp_i) + 1'b1)));
    // R8: wake only while halted
    p_wake_in_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> stop_i);
endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]  req = '0;
    logic [2:0]  en = 3'b111;
    logic        boundary = 1'b1, ret = 1'b0, stop = 1'b0;
    logic [13:0] pc_r;
    logic [5:0]  page_r;
    logic [7:0]  ps_r, sp_r;
    logic        mem_we, sp_ld, pc_ld, page_ld, ps_ld, ack, busy, wake;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata, sp_nxt, ps_nxt;
    logic [13:0] pc_nxt;
    logic [5:0]  page_nxt;
    logic [1:0]  ack_src;
    logic [7:0]  mem [256];

    logic        pre_en = 1'b0;
    logic [13:0] pre_pc = '0;
    logic [5:0]  pre_page = '0;
    logic [7:0]  pre_ps = '0, pre_sp = 8'hFF;

    int errors = 0;
    int checks = 0;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .irq_en_i(en),
        .boundary_i(boundary), .ret_i(ret), .stop_i(stop),
        .cur_pc_i(pc_r), .cur_page_i(page_r), .cur_ps_i(ps_r), .cur_sp_i(sp_r),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .sp_ld_o(sp_ld), .sp_nxt_o(sp_nxt),
        .pc_ld_o(pc_ld), .pc_nxt_o(pc_nxt), .page_ld_o(page_ld),
        .page_nxt_o(page_nxt), .ps_ld_o(ps_ld), .ps_nxt_o(ps_nxt),
        .ack_o(ack), .ack_src_o(ack_src), .busy_o(busy), .wake_o(wake)
    );

    // core register and stack memory model
    always_ff @(posedge clk) begin
        if (pre_en) begin
            pc_r <= pre_pc; page_r <= pre_page; ps_r <= pre_ps; sp_r <= pre_sp;
        end else begin
            if (pc_ld)   pc_r   <= pc_nxt;
            if (page_ld) page_r <= page_nxt;
            if (ps_ld)   ps_r   <= ps_nxt;
            if (sp_ld)   sp_r   <= sp_nxt;
        end
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic preset(input logic [13:0] p, input logic [5:0] g,
                          input logic [7:0] s, input logic [7:0] sp);
        @(negedge clk);
        pre_pc = p; pre_page = g; pre_ps = s; pre_sp = sp; pre_en = 1'b1;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] r);
        @(negedge clk);
        req = r;
        @(negedge clk);
        req = '0;
    endtask

    task automatic no_ack(input int n, input string tag);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            #1;
            if (ack) seen++;
            @(negedge clk);
        end
        check(seen == 0, tag, seen, 0);
    endtask

    task automatic serve_one(input int exp_src, input logic [13:0] op,
                             input logic [5:0] og, input logic [7:0] os,
                             input logic [7:0] osp);
        bit got = 0;
        int n;
        for (int k = 0; k < 30; k++) begin
            #1;
            if (ack) begin got = 1; break; end
            @(negedge clk);
        end
        check(got, "R1 ack seen", int'(got), 1);
        if (!got) return;
        check(int'(ack_src) == exp_src, "R1 winner code", int'(ack_src), exp_src);
        n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 20);
        check(n == 5, "R3 entry length", n, 5);
        check(mem[osp] == op[7:0], "R3 pc low byte", int'(mem[osp]), int'(op[7:0]));
        check(mem[8'(osp - 1)] == {2'b00, op[13:8]}, "R3 pc high byte",
              int'(mem[8'(osp - 1)]), int'(op[13:8]));
        check(mem[8'(osp - 2)] == {2'b00, og}, "R3 page byte",
              int'(mem[8'(osp - 2)]), int'(og));
        check(mem[8'(osp - 3)] == os, "R3 status byte", int'(mem[8'(osp - 3)]), int'(os));
        check(sp_r == 8'(osp - 4), "R3 sp after entry", int'(sp_r), int'(8'(osp - 4)));
        check(int'(pc_r) == 'h3FF0 - 16 * exp_src, "R2 vector", int'(pc_r),
              'h3FF0 - 16 * exp_src);
        check(page_r == 6'd3, "R4 page", int'(page_r), 3);
        check(ps_r == (os | 8'h10), "R4 mask set", int'(ps_r), int'(os | 8'h10));
        ret = 1'b1;
        @(negedge clk);
        ret = 1'b0;
        n = 1;
        while (busy && n < 20) begin @(negedge clk); n++; end
        check(n == 6, "R6 return length", n, 6);
        check(pc_r == op, "R6 pc restored", int'(pc_r), int'(op));
        check(page_r == og, "R6 page restored", int'(page_r), int'(og));
        check(ps_r == os, "R6 status restored", int'(ps_r), int'(os));
        check(sp_r == osp, "R6 sp restored", int'(sp_r), int'(osp));
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        pre_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pre_en = 1'b0;
        #1;
        // R10 reset state
        check(!busy && !ack && !mem_we && !wake, "R10 reset outputs",
              {busy, ack, mem_we, wake}, 0);
        no_ack(4, "R10 nothing pending after reset");

        // R1 R9: sweep every set of simultaneous requests
        for (int c = 1; c < 16; c++) begin
            logic [13:0] op = 14'((16'h02A5 + c * 16'h03C1));
            logic [5:0]  og = 6'(c * 5);
            logic [7:0]  os = 8'(c * 37) & 8'hEF;
            logic [7:0]  osp = 8'(8'hFF - c * 3);
            preset(op, og, os, osp);
            pulse(4'(c));
            for (int s = 0; s < 4; s++)
                if (c[s]) serve_one(s, op, og, os, osp);
            no_ack(3, "R9 all served");
        end

        // R5: masked requests wait
        preset(14'h1234, 6'h21, 8'h10, 8'hF0);
        pulse(4'b0110);
        no_ack(8, "R5 no accept while masked");
        preset(14'h1234, 6'h21, 8'h00, 8'hF0);
        serve_one(1, 14'h1234, 6'h21, 8'h00, 8'hF0);
        serve_one(2, 14'h1234, 6'h21, 8'h00, 8'hF0);

        // R7: enables
        en = 3'b110;
        pulse(4'b0001);
        no_ack(6, "R7 disabled source held");
        @(negedge clk);
        en = 3'b111;
        serve_one(0, 14'h1234, 6'h21, 8'h00, 8'hF0);
        en = 3'b000;
        pulse(4'b1000);
        serve_one(3, 14'h1234, 6'h21, 8'h00, 8'hF0);
        en = 3'b111;

        // R11: boundary gating
        boundary = 1'b0;
        pulse(4'b0100);
        no_ack(6, "R11 no accept off boundary");
        boundary = 1'b1;
        serve_one(2, 14'h1234, 6'h21, 8'h00, 8'hF0);

        // R8: wake from stop
        boundary = 1'b0;
        stop = 1'b1;
        en = 3'b100;
        pulse(4'b0100);
        #1;
        check(wake, "R8 wake on external", int'(wake), 1);
        en = 3'b000;
        #1;
        check(!wake, "R8 no wake when disabled", int'(wake), 0);
        en = 3'b100;
        stop = 1'b0;
        #1;
        check(!wake, "R8 no wake when running", int'(wake), 0);
        @(negedge clk);
        boundary = 1'b1;
        en = 3'b111;
        serve_one(2, 14'h1234, 6'h21, 8'h00, 8'hF0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule